// File: doc/BRIEF.md
# Capability Data Access Checker

This block is purely combinational. It decides whether one data memory operation may proceed under the capability that authorizes it. The operation is a load, a store, an atomic, or one of four cache-block operations (zero, invalidate, clean, flush).

The block receives the following inputs:
- the capability's tag, sealed flag, read, write and system-register permissions, decoded base and top, and malformed-bounds flag;
- the effective address, the access size, the operation class and the cache block size;
- the system-register permission of the program-counter capability.

When any check fails, the block raises one fault. It picks a single cause code using a fixed priority and labels the fault as a data fault or an instruction-side fault. Independently of that, a capability-width load or store that is not naturally aligned raises a standard misalignment exception code.

The block sits in the memory stage of a pipeline, after capability decompression. Its outputs feed the trap logic. It holds no state: every output is a function of the present inputs.

Top module: `cap_data_access_chk`

## Requirements
- R1: With the tag clear, the block raises a fault with cause 0 and type data (2), whatever else is wrong.
- R2: Below R1 and R11, causes rank sealed (1), then permission (2), then invalid address (3), then bounds (4). Codes 5 to 15 never appear.
- R3: Permission rules for op_class 0 (load), 1 (store), 2 (atomic) and 3 (block zero): a load needs read permission; a store, an atomic and a block zero each need write permission.
- R4: A block invalidate (op_class 4) needs read, write and system-register permission on the authorizing capability.
- R5: A block clean (op_class 5) or block flush (op_class 6) has a permission fault only when the capability grants neither read nor write.
- R6: For loads, stores and atomics, the access covers [addr, addr+size) and faults with the bounds cause when any byte of it lies outside [base, top). The size is 1<<acc_size_log2, or 1<<CAP_LOG2 for a capability-width access. The sum is formed one bit wider than the address, so it never wraps.
- R7: For block zero and block invalidate, the block is the address rounded down to a multiple of 1<<blk_size_log2, and it is checked in full. The operation faults with the bounds cause when any byte of that block is outside the bounds.
- R8: For block clean and block flush, the bounds cause applies only when every byte of the aligned block is outside the bounds.
- R9: A capability flagged malformed always yields the bounds cause when no higher cause applies.
- R10: An address is invalid, cause 3, when bits XLEN-1 down to VA_BITS-1 are not all equal.
- R11: A block invalidate whose program-counter capability lacks system-register permission reports cause 2 with type instruction (1). This ranks just below R1 and above every data cause.
- R12: A capability-width load with address bits below CAP_LOG2 not all zero raises misalign_exc with code 4. A capability-width store or atomic raises code 6. This is independent of the capability fault, and block operations never raise it.
- R13: With no failing check, cheri_fault is 0, cheri_type is none (0) and cheri_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| auth_tag | input | 1 | Capability tag is valid |
| auth_sealed | input | 1 | Capability is sealed |
| auth_perm_rd | input | 1 | Read permission |
| auth_perm_wr | input | 1 | Write permission |
| auth_perm_sys | input | 1 | System-register permission of the capability |
| auth_base | input | XLEN | Inclusive lower bound |
| auth_top | input | XLEN+1 | Exclusive upper bound |
| auth_malformed | input | 1 | Bounds are malformed |
| eff_addr | input | XLEN | Effective address |
| acc_size_log2 | input | SZW | log2 of access bytes for non-capability accesses |
| acc_cap_width | input | 1 | Access is capability-width |
| op_class | input | 3 | Operation class, encoded as listed in R3 to R5 |
| blk_size_log2 | input | CBW | log2 of cache block bytes |
| pcc_perm_sys | input | 1 | System-register permission of the program-counter capability |
| cheri_fault | output | 1 | A capability check failed |
| cheri_type | output | 2 | 0 none, 1 instruction, 2 data |
| cheri_cause | output | 4 | Cause code |
| misalign_exc | output | 1 | Standard misalignment exception |
| misalign_code | output | 4 | 4 for load, 6 for store or atomic |

## Verification
A capability fault and the misalignment exception can both occur for the same operation. This happens when a capability-width load or store sits at an odd address and also breaks a permission, address or bounds rule. The bench sweeps such operations across all flag combinations at odd addresses. It judges the two outputs separately, each against its own rule, so that neither is allowed to mask the other. A second sweep covers every address against several bound pairs and every block size, which exercises the any-byte and all-bytes edges at base and top.

// File: rtl/capchk_pkg.sv
package capchk_pkg;

    typedef enum logic [2:0] {
        OP_LOAD      = 3'd0,
        OP_STORE     = 3'd1,
        OP_AMO       = 3'd2,
        OP_BLK_ZERO  = 3'd3,
        OP_BLK_INVAL = 3'd4,
        OP_BLK_CLEAN = 3'd5,
        OP_BLK_FLUSH = 3'd6
    } mem_op_e;

    typedef enum logic [1:0] {
        FT_NONE  = 2'd0,
        FT_INSTR = 2'd1,
        FT_DATA  = 2'd2
    } flt_type_e;

    typedef enum logic [3:0] {
        CZ_TAG    = 4'd0,
        CZ_SEAL   = 4'd1,
        CZ_PERM   = 4'd2,
        CZ_ADDR   = 4'd3,
        CZ_BOUNDS = 4'd4
    } flt_cause_e;

    localparam logic [3:0] EXC_LD_MISALIGN = 4'd4;
    localparam logic [3:0] EXC_ST_MISALIGN = 4'd6;

    typedef struct packed {
        logic tag;
        logic sealed;
        logic perm_rd;
        logic perm_wr;
        logic perm_sys;
        logic malformed;
    } cap_meta_t;

    typedef struct packed {
        logic instr_perm;
        logic seal;
        logic perm;
        logic addr;
        logic bnds;
    } viol_t;

    function automatic logic is_block_op(mem_op_e op);
        return (op == OP_BLK_ZERO) || (op == OP_BLK_INVAL) ||
               (op == OP_BLK_CLEAN) || (op == OP_BLK_FLUSH);
    endfunction

    function automatic logic uses_all_bytes(mem_op_e op);
        return (op == OP_BLK_CLEAN) || (op == OP_BLK_FLUSH);
    endfunction

endpackage

// File: rtl/capchk_region.sv
module capchk_region
    import capchk_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int SZW      = 2,
    parameter int CBW      = 3,
    parameter int CAP_LOG2 = 3
) (
    input  logic [XLEN-1:0] addr,
    input  logic [SZW-1:0]  size_log2,
    input  logic            cap_width,
    input  logic [CBW-1:0]  blk_log2,
    input  mem_op_e         op,
    output logic [XLEN:0]   lo,
    output logic [XLEN:0]   hi
);
    localparam logic [XLEN:0] ONE = {{XLEN{1'b0}}, 1'b1};

    logic [XLEN:0] acc_len;
    logic [XLEN:0] blk_len;
    logic [XLEN:0] blk_mask;
    logic [XLEN:0] wide_addr;

    always_comb begin
        wide_addr = {1'b0, addr};
        acc_len   = cap_width ? (ONE << CAP_LOG2) : (ONE << size_log2);
        blk_len   = ONE << blk_log2;
        blk_mask  = ~(blk_len - ONE);
        if (is_block_op(op)) begin
            lo = wide_addr & blk_mask;
            hi = lo + blk_len;
        end else begin
            lo = wide_addr;
            hi = wide_addr + acc_len;
        end
    end

    // R6
    always_comb begin
        if (!$isunknown({addr, size_log2, cap_width, blk_log2, op}))
            region_nonempty_chk: assert (hi > lo);
    end

endmodule

// File: rtl/capchk_bounds.sv
module capchk_bounds #(
    parameter int XLEN = 32
) (
    input  logic [XLEN:0]   lo,
    input  logic [XLEN:0]   hi,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN:0]   top,
    input  logic            all_mode,
    output logic            out_of_bounds
);
    logic [XLEN:0] wide_base;
    logic          some_out;
    logic          every_out;

    always_comb begin
        wide_base     = {1'b0, base};
        some_out      = (lo < wide_base) || (hi > top);
        every_out     = (hi <= wide_base) || (lo >= top);
        out_of_bounds = all_mode ? every_out : some_out;
    end

    // R8
    always_comb begin
        if (!$isunknown({lo, hi, base, top}) && (hi > lo))
            all_implies_any_chk: assert (!every_out || some_out);
    end

endmodule

// File: rtl/capchk_addr.sv
module capchk_addr #(
    parameter int XLEN    = 32,
    parameter int VA_BITS = 25
) (
    input  logic [XLEN-1:0] addr,
    output logic            addr_bad
);
    generate
        if (VA_BITS >= XLEN) begin : g_full
            logic unused_addr;
            assign unused_addr = ^addr;
            assign addr_bad    = 1'b0;
        end else begin : g_canon
            localparam int HIW = XLEN - VA_BITS + 1;
            logic [HIW-1:0] upper;
            assign upper    = addr[XLEN-1:VA_BITS-1];
            assign addr_bad = !((upper == '0) || (upper == '1));
        end
    endgenerate
endmodule

// File: rtl/capchk_perm.sv
module capchk_perm
    import capchk_pkg::*;
(
    input  mem_op_e   op,
    input  cap_meta_t meta,
    input  logic      pcc_sys,
    output logic      data_perm_bad,
    output logic      instr_perm_bad
);
    always_comb begin
        instr_perm_bad = (op == OP_BLK_INVAL) && !pcc_sys;
        case (op)
            OP_STORE, OP_AMO, OP_BLK_ZERO:
                data_perm_bad = !meta.perm_wr;
            OP_BLK_INVAL:
                data_perm_bad = !(meta.perm_rd && meta.perm_wr && meta.perm_sys);
            OP_BLK_CLEAN, OP_BLK_FLUSH:
                data_perm_bad = !meta.perm_rd && !meta.perm_wr;
            default:
                data_perm_bad = !meta.perm_rd;
        endcase
    end

    // R5
    always_comb begin
        if (!$isunknown({op, meta}) && uses_all_bytes(op) && (meta.perm_rd || meta.perm_wr))
            clean_perm_chk: assert (!data_perm_bad);
    end

endmodule

// File: rtl/cap_data_access_chk.sv
module cap_data_access_chk
    import capchk_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VA_BITS  = 25,
    parameter int SZW      = 2,
    parameter int CBW      = 3,
    parameter int CAP_LOG2 = 3
) (
    input  logic            auth_tag,
    input  logic            auth_sealed,
    input  logic            auth_perm_rd,
    input  logic            auth_perm_wr,
    input  logic            auth_perm_sys,
    input  logic [XLEN-1:0] auth_base,
    input  logic [XLEN:0]   auth_top,
    input  logic            auth_malformed,
    input  logic [XLEN-1:0] eff_addr,
    input  logic [SZW-1:0]  acc_size_log2,
    input  logic            acc_cap_width,
    input  logic [2:0]      op_class,
    input  logic [CBW-1:0]  blk_size_log2,
    input  logic            pcc_perm_sys,
    output logic            cheri_fault,
    output logic [1:0]      cheri_type,
    output logic [3:0]      cheri_cause,
    output logic            misalign_exc,
    output logic [3:0]      misalign_code
);
    mem_op_e       op;
    cap_meta_t     meta;
    viol_t         viol;
    logic [XLEN:0] reg_lo;
    logic [XLEN:0] reg_hi;
    logic          bnd_hit;
    logic          data_perm_bad;
    logic          instr_perm_bad;
    logic          addr_bad;

    assign op   = mem_op_e'(op_class);
    assign meta = '{tag: auth_tag, sealed: auth_sealed, perm_rd: auth_perm_rd,
                    perm_wr: auth_perm_wr, perm_sys: auth_perm_sys,
                    malformed: auth_malformed};

    capchk_region #(.XLEN(XLEN), .SZW(SZW), .CBW(CBW), .CAP_LOG2(CAP_LOG2)) u_region (
        .addr(eff_addr), .size_log2(acc_size_log2), .cap_width(acc_cap_width),
        .blk_log2(blk_size_log2), .op(op), .lo(reg_lo), .hi(reg_hi)
    );

    capchk_bounds #(.XLEN(XLEN)) u_bounds (
        .lo(reg_lo), .hi(reg_hi), .base(auth_base), .top(auth_top),
        .all_mode(uses_all_bytes(op)), .out_of_bounds(bnd_hit)
    );

    capchk_addr #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_addr (
        .addr(eff_addr), .addr_bad(addr_bad)
    );

    capchk_perm u_perm (
        .op(op), .meta(meta), .pcc_sys(pcc_perm_sys),
        .data_perm_bad(data_perm_bad), .instr_perm_bad(instr_perm_bad)
    );

    always_comb begin
        viol.instr_perm = instr_perm_bad;
        viol.seal       = meta.sealed;
        viol.perm       = data_perm_bad;
        viol.addr       = addr_bad;
        viol.bnds       = meta.malformed || bnd_hit;
    end

    always_comb begin
        cheri_fault = 1'b1;
        cheri_type  = FT_DATA;
        cheri_cause = CZ_TAG;
        if (!meta.tag) begin
            cheri_cause = CZ_TAG;
        end else if (viol.instr_perm) begin
            cheri_type  = FT_INSTR;
            cheri_cause = CZ_PERM;
        end else if (viol.seal) begin
            cheri_cause = CZ_SEAL;
        end else if (viol.perm) begin
            cheri_cause = CZ_PERM;
        end else if (viol.addr) begin
            cheri_cause = CZ_ADDR;
        end else if (viol.bnds) begin
            cheri_cause = CZ_BOUNDS;
        end else begin
            cheri_fault = 1'b0;
            cheri_type  = FT_NONE;
            cheri_cause = CZ_TAG;
        end
    end

    always_comb begin
        misalign_exc  = acc_cap_width && !is_block_op(op) && (eff_addr[CAP_LOG2-1:0] != '0);
        misalign_code = !misalign_exc ? 4'd0 :
                        (op == OP_LOAD) ? EXC_LD_MISALIGN : EXC_ST_MISALIGN;
    end

    always_comb begin
        if (!$isunknown({auth_tag, auth_sealed, auth_perm_rd, auth_perm_wr, auth_perm_sys,
                         auth_base, auth_top, auth_malformed, eff_addr, acc_size_log2,
                         acc_cap_width, op_class, blk_size_log2, pcc_perm_sys})) begin
            // R2
            reserved_cause_chk: assert (cheri_cause <= 4'd4);
            // R1
            tag_first_chk: assert (auth_tag || (cheri_fault && cheri_cause == 4'd0));
            // R11
            instr_type_chk: assert (cheri_type != 2'd1 || (op_class == 3'd4 && !pcc_perm_sys));
            // R13
            quiet_chk: assert (cheri_fault || (cheri_type == 2'd0 && cheri_cause == 4'd0));
            // R12
            misalign_code_chk: assert (!misalign_exc || misalign_code == 4'd4 || misalign_code == 4'd6);
            // R9
            malformed_chk: assert (!(auth_tag && auth_malformed) || cheri_fault);
        end
    end

endmodule

// File: tb/tb_cap_data_access_chk.sv
module tb_cap_data_access_chk;
    localparam int XLEN = 8, VA_BITS = 6, SZW = 2, CBW = 3, CAP_LOG2 = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic            tag, sealed, prd, pwr, psys, mal, pccsys, capw;
    logic [XLEN-1:0] base, addr;
    logic [XLEN:0]   top;
    logic [SZW-1:0]  szl;
    logic [2:0]      opc;
    logic [CBW-1:0]  blk;
    logic            fault, mis;
    logic [1:0]      ftype;
    logic [3:0]      cause, mcode;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    cap_data_access_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS), .SZW(SZW), .CBW(CBW),
                          .CAP_LOG2(CAP_LOG2)) dut (
        .auth_tag(tag), .auth_sealed(sealed), .auth_perm_rd(prd), .auth_perm_wr(pwr),
        .auth_perm_sys(psys), .auth_base(base), .auth_top(top), .auth_malformed(mal),
        .eff_addr(addr), .acc_size_log2(szl), .acc_cap_width(capw), .op_class(opc),
        .blk_size_log2(blk), .pcc_perm_sys(pccsys), .cheri_fault(fault),
        .cheri_type(ftype), .cheri_cause(cause), .misalign_exc(mis), .misalign_code(mcode)
    );

    task automatic check_now();
        int lo, hi, len, up;
        bit blkop, allm, some_o, every_o, bnd, pbad, abad;
        logic ef; logic [1:0] et; logic [3:0] ec; logic em; logic [3:0] emc;
        string rq;
        #2;
        blkop = (opc >= 3 && opc <= 6);
        allm  = (opc == 5 || opc == 6);
        if (blkop) begin
            len = 1 << blk;
            lo  = (int'(addr) / len) * len;
        end else begin
            len = capw ? (1 << CAP_LOG2) : (1 << szl);
            lo  = int'(addr);
        end
        hi      = lo + len;
        some_o  = (lo < int'(base)) || (hi > int'(top));
        every_o = (hi <= int'(base)) || (lo >= int'(top));
        bnd     = mal || (allm ? every_o : some_o);
        case (opc)
            3'd1, 3'd2, 3'd3: pbad = !pwr;
            3'd4:             pbad = !(prd && pwr && psys);
            3'd5, 3'd6:       pbad = !prd && !pwr;
            default:          pbad = !prd;
        endcase
        up   = int'(addr) >> (VA_BITS - 1);
        abad = !(up == 0 || up == (1 << (XLEN - VA_BITS + 1)) - 1);
        ef = 1; et = 2; ec = 0;
        if (!tag)                      begin ec = 0; rq = "R1"; end
        else if (opc == 4 && !pccsys)  begin et = 1; ec = 2; rq = "R11"; end
        else if (sealed)               begin ec = 1; rq = "R2"; end
        else if (pbad)                 begin ec = 2; rq = (opc == 4) ? "R4" : allm ? "R5" : "R3"; end
        else if (abad)                 begin ec = 3; rq = "R10"; end
        else if (bnd)                  begin ec = 4; rq = mal ? "R9" : allm ? "R8" : blkop ? "R7" : "R6"; end
        else                           begin ef = 0; et = 0; ec = 0; rq = "R13"; end
        em  = capw && !blkop && (addr % (1 << CAP_LOG2) != 0);
        emc = !em ? 4'd0 : (opc == 0) ? 4'd4 : 4'd6;
        n_checks++;
        if (fault !== ef || ftype !== et || cause !== ec) begin
            n_fails++;
            $display("FAIL %s op=%0d addr=%0d base=%0d top=%0d: got f=%0b t=%0d c=%0d, expected f=%0b t=%0d c=%0d",
                     rq, opc, addr, base, top, fault, ftype, cause, ef, et, ec);
        end
        n_checks++;
        if (mis !== em || mcode !== emc) begin
            n_fails++;
            $display("FAIL R12 op=%0d addr=%0d: got m=%0b code=%0d, expected m=%0b code=%0d",
                     opc, addr, mis, mcode, em, emc);
        end
    endtask

    task automatic set_good();
        tag = 1; sealed = 0; prd = 1; pwr = 1; psys = 1; mal = 0; pccsys = 1;
    endtask

    initial begin
        set_good();
        capw = 0; szl = 0; opc = 0; blk = 0; base = 0; top = 9'd256; addr = 8'h10;
        repeat (3) @(posedge clk);
        check_now();                        // R13 quiet state during reset
        rst = 1'b0;
        @(negedge clk);

        // bounds sweep: R6 R7 R8 with every address and size
        for (int o = 0; o < 7; o++)
            for (int k = 0; k < 5; k++)
                for (int p = 0; p < 6; p++)
                    for (int a = 0; a < 256; a++) begin
                        set_good();
                        opc  = 3'(o);
                        capw = (o < 3) && (k == 4);
                        szl  = 2'(k);
                        blk  = 3'(k);
                        case (p)
                            0: begin base = 0;   top = 9'd256; end
                            1: begin base = 16;  top = 9'd48;  end
                            2: begin base = 37;  top = 9'd38;  end
                            3: begin base = 100; top = 9'd228; end
                            4: begin base = 250; top = 9'd256; end
                            default: begin base = 64; top = 9'd64; end
                        endcase
                        addr = 8'(a);
                        check_now();
                    end

        // flag sweep: R1 R2 R3 R4 R5 R9 R10 R11, with R12 overlap at odd addresses
        for (int o = 0; o < 7; o++)
            for (int f = 0; f < 128; f++)
                for (int ai = 0; ai < 4; ai++)
                    for (int p = 0; p < 2; p++)
                        for (int k = 0; k < 2; k++) begin
                            {tag, sealed, prd, pwr, psys, mal, pccsys} = 7'(f);
                            opc  = 3'(o);
                            capw = (k == 1);
                            szl  = (k == 1) ? 2'd1 : 2'd0;
                            blk  = (k == 1) ? 3'd2 : 3'd0;
                            case (ai)
                                0: addr = 8'h10;
                                1: addr = 8'h11;
                                2: addr = 8'h40;
                                default: addr = 8'h1F;
                            endcase
                            if (p == 0) begin base = 8'h10; top = 9'h20; end
                            else        begin base = 8'h30; top = 9'h40; end
                            check_now();
                        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule